// File: doc/BRIEF.md
# Resolution-Configurable Conversion Controller

This block owns the 8-bit configuration byte of a temperature sensing path and paces each conversion. Software writes the byte to choose one of four result precisions and reads it back together with a live supply-health flag. A start request launches a conversion whose length is the worst-case duration for the chosen precision, counted in clock cycles. When the count expires, the block takes the raw 16-bit converter word, clears every bit below the selected precision, holds the masked word on `result`, and pulses `done`.

A soft reset command puts the configuration back to its power-on value and abandons any running conversion. It then holds the block in a settling window of 15 ms. No new conversion can start during that window. The time base is the parameter `TICKS_PER_TENTH`, which gives the number of clock cycles in 0.1 ms. Every duration is a whole multiple of it: 108, 62, 38 and 24 tenths for 14, 13, 12 and 11 bits, and 150 tenths for settling.

Top module: `tconv_ctrl`

## Requirements
- R1: After the asynchronous reset, with `supply_low` at 0, `cfg_rd_data` reads 8'h3A, `busy`, `settling` and `done` are 0, and `result` is 0.
- R2: The precision code is {bit 7, bit 0} of the configuration byte. The code values are 00 for 14 bits, 01 for 12 bits, 10 for 13 bits and 11 for 11 bits. A write stores bits 7 and 0, and a read returns them in the same positions.
- R3: Bit 6 of `cfg_rd_data` always equals `supply_low`, and the value written to bit 6 has no effect on it.
- R4: Bits 5 down to 1 of `cfg_rd_data` always read 5'b11101, whatever is written.
- R5: `result` is the raw word with only its top N bits kept, N being the precision in force for that conversion. Bits 1 and 0 of `result` are always 0.
- R6: A start accepted while idle raises `busy` at the next clock edge. `busy` stays high for exactly T×`TICKS_PER_TENTH` cycles, where T is 108, 62, 38 or 24 for 14, 13, 12 or 11 bits. `done` is high for the single cycle after `busy` falls.
- R7: A start request while `busy` or `settling` is high is ignored, and the running interval keeps its length.
- R8: `soft_reset` clears `busy` at the next edge without a `done` pulse and restores the configuration to its reset value. It then holds `settling` high for 150×`TICKS_PER_TENTH` cycles. `soft_reset` takes priority over a write or a start in the same cycle.
- R9: The precision is latched when a conversion starts. A configuration write during `busy` changes neither the length nor the masking of that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration write value |
| cfg_rd_data | output | 8 | Configuration readback |
| supply_low | input | 1 | Supply-health status, 1 means low |
| start | input | 1 | Conversion start request |
| soft_reset | input | 1 | Soft reset command |
| adc_raw | input | 16 | Raw converter word |
| busy | output | 1 | Conversion running |
| settling | output | 1 | Post soft-reset recovery window |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Masked conversion result |

## Verification
The bench builds the block with `TICKS_PER_TENTH` = 2. At that value the longest conversion is 216 cycles and the settling window is 300 cycles. Every precision, back-to-back conversions and a full soft-reset recovery can therefore be counted cycle by cycle within a short run. The time base enters the logic only as a multiplier on the load value of the counter. Keeping it small therefore brings the exact length of each interval within reach without changing the structure that the default value produces.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

  typedef enum logic [1:0] {
    RES14 = 2'b00,
    RES12 = 2'b01,
    RES13 = 2'b10,
    RES11 = 2'b11
  } res_code_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CONV,
    PH_SETTLE
  } phase_e;

  localparam int unsigned SETTLE_TENTHS = 150;
  localparam int unsigned MAX_TENTHS    = 150;
  localparam logic [7:0]  CFG_RESET     = 8'h3A;
  localparam logic [4:0]  RSVD_PATTERN  = 5'b11101;

  function automatic int unsigned res_bits(res_code_e r);
    case (r)
      RES14:   return 14;
      RES13:   return 13;
      RES12:   return 12;
      default: return 11;
    endcase
  endfunction

  function automatic int unsigned res_tenths(res_code_e r);
    case (r)
      RES14:   return 108;
      RES13:   return 62;
      RES12:   return 38;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/tconv_cfg.sv
module tconv_cfg
  import tconv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [7:0] wr_data,
  input  logic      soft_reset,
  input  logic      supply_low,
  output logic [7:0] rd_data,
  output res_code_e res_sel
);

  res_code_e res_q, res_d;
  logic      res_en;
  logic      unused_wr_bits;

  assign unused_wr_bits = ^wr_data[6:1];

  always_comb begin
    res_en = soft_reset | wr_en;
    res_d  = res_q;
    if (soft_reset)
      res_d = res_code_e'({CFG_RESET[7], CFG_RESET[0]});
    else if (wr_en)
      res_d = res_code_e'({wr_data[7], wr_data[0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      res_q <= res_code_e'({CFG_RESET[7], CFG_RESET[0]});
    else if (res_en)
      res_q <= res_d;
  end

  assign res_sel = res_q;
  assign rd_data = {res_q[1], supply_low, RSVD_PATTERN, res_q[0]};

  // R2: a plain write lands in the stored code
  a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_reset) |=> (res_sel == res_code_e'({$past(wr_data[7]), $past(wr_data[0])})));

endmodule

// File: rtl/tconv_seq.sv
module tconv_seq
  import tconv_pkg::*;
#(
  parameter int unsigned TICKS_PER_TENTH = 10000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      soft_reset,
  input  res_code_e res_sel,
  output logic      busy,
  output logic      settling,
  output logic      done,
  output logic      conv_end,
  output res_code_e res_held
);

  localparam int unsigned CNT_MAX = MAX_TENTHS * TICKS_PER_TENTH;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  phase_e          ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  res_code_e       held_q, held_d;
  logic            done_d;
  logic            zero;

  assign zero = (cnt_q == '0);

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    held_d   = held_q;
    conv_end = 1'b0;
    if (soft_reset) begin
      ph_d  = PH_SETTLE;
      cnt_d = CNT_W'(SETTLE_TENTHS * TICKS_PER_TENTH - 1);
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_d   = PH_CONV;
          held_d = res_sel;
          cnt_d  = CNT_W'(res_tenths(res_sel) * TICKS_PER_TENTH - 1);
        end
        PH_CONV: if (zero) begin
          ph_d     = PH_IDLE;
          conv_end = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
        PH_SETTLE: if (zero) ph_d = PH_IDLE;
                   else       cnt_d = cnt_q - 1'b1;
        default: ph_d = PH_IDLE;
      endcase
    end
    done_d = conv_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      held_q <= RES14;
      done   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      held_q <= held_d;
      done   <= done_d;
    end
  end

  assign busy     = (ph_q == PH_CONV);
  assign settling = (ph_q == PH_SETTLE);
  assign res_held = held_q;

  // R6: completion pulse lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: a start during a running interval does not cut it short
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !soft_reset && !zero) |=> busy);
  // R8: soft reset aborts and enters settling
  a_r8_reset_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> (!busy && settling && !done));
  // R9: precision stays fixed while a conversion runs
  a_r9_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(res_held));

endmodule

// File: rtl/tconv_mask.sv
module tconv_mask
  import tconv_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  res_code_e         res_sel,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned ALWAYS_ZERO = 2;

  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] result_q;
  int unsigned       keep;

  assign keep = res_bits(res_sel);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < ALWAYS_ZERO) begin : g_zero
      assign masked[i] = 1'b0;
    end else begin : g_keep
      assign masked[i] = raw[i] & (i >= (DATA_W - keep));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      result_q <= '0;
    else if (capture)
      result_q <= masked;
  end

  assign result = result_q;

endmodule

// File: rtl/tconv_ctrl.sv
module tconv_ctrl
  import tconv_pkg::*;
#(
  parameter int unsigned TICKS_PER_TENTH = 10000,
  parameter int unsigned DATA_W          = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_wr_data,
  output logic [7:0]        cfg_rd_data,
  input  logic              supply_low,
  input  logic              start,
  input  logic              soft_reset,
  input  logic [DATA_W-1:0] adc_raw,
  output logic              busy,
  output logic              settling,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  res_code_e res_sel;
  res_code_e res_held;
  logic      conv_end;

  tconv_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_data    (cfg_wr_data),
    .soft_reset (soft_reset),
    .supply_low (supply_low),
    .rd_data    (cfg_rd_data),
    .res_sel    (res_sel)
  );

  tconv_seq #(.TICKS_PER_TENTH(TICKS_PER_TENTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .soft_reset (soft_reset),
    .res_sel    (res_sel),
    .busy       (busy),
    .settling   (settling),
    .done       (done),
    .conv_end   (conv_end),
    .res_held   (res_held)
  );

  tconv_mask #(.DATA_W(DATA_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (conv_end),
    .res_sel (res_held),
    .raw     (adc_raw),
    .result  (result)
  );

  // R3: status bit follows the supply input
  a_r3_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[6] == supply_low);
  // R4: reserved field is fixed
  a_r4_rsvd_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[5:1] == 5'b11101);
  // R5: two lowest result bits never set
  a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    result[1:0] == 2'b00);
  // R6: done only ends a conversion
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R8: soft reset restores the configuration byte
  a_r8_cfg_restored: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> ({cfg_rd_data[7], cfg_rd_data[0]} == 2'b00));

endmodule

// File: tb/tconv_ctrl_tb.sv
module tconv_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_data;
  logic [7:0]  cfg_rd_data;
  logic        supply_low;
  logic        start;
  logic        soft_reset;
  logic [15:0] adc_raw;
  logic        busy;
  logic        settling;
  logic        done;
  logic [15:0] result;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tconv_ctrl #(.TICKS_PER_TENTH(TICKS), .DATA_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .supply_low(supply_low), .start(start),
    .soft_reset(soft_reset), .adc_raw(adc_raw), .busy(busy), .settling(settling),
    .done(done), .result(result)
  );

  function automatic int exp_cycles(logic [7:0] cfg);
    case ({cfg[7], cfg[0]})
      2'b00:   return 108 * TICKS;
      2'b10:   return 62 * TICKS;
      2'b01:   return 38 * TICKS;
      default: return 24 * TICKS;
    endcase
  endfunction

  function automatic logic [15:0] exp_result(logic [7:0] cfg, logic [15:0] raw);
    int n;
    case ({cfg[7], cfg[0]})
      2'b00:   n = 14;
      2'b10:   n = 13;
      2'b01:   n = 12;
      default: n = 11;
    endcase
    return raw & (16'hFFFF << (16 - n));
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] cfg, logic sl);
    return {cfg[7], sl, 5'b11101, cfg[0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [7:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // runs a conversion; optional disturbance at mid-point
  task automatic run_conv(logic [7:0] cfg, logic [15:0] raw, bit poke_start,
                          bit poke_write, logic [7:0] poke_val, string req);
    int n = 0;
    int mid = exp_cycles(cfg) / 2;
    write_cfg(cfg);
    adc_raw = raw;
    pulse_start();
    while (busy) begin
      n++;
      if (n == mid && poke_start) begin start = 1'b1; end
      else if (n == mid && poke_write) begin cfg_wr_en = 1'b1; cfg_wr_data = poke_val; end
      @(negedge clk);
      start = 1'b0; cfg_wr_en = 1'b0;
    end
    check({req, " length"}, n, exp_cycles(cfg));
    check({req, " done"}, done, 1'b1);
    check({req, " result"}, result, exp_result(cfg, raw));
    @(negedge clk);
    check({req, " done one cycle"}, done, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] c;
    logic [15:0] r;
    int n;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_wr_en = 0; cfg_wr_data = 0; supply_low = 0;
    start = 0; soft_reset = 0; adc_raw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cfg", cfg_rd_data, 8'h3A);
    check("R1 busy", {busy, settling, done}, 3'b000);
    check("R1 result", result, 16'h0000);

    // R3 status bit follows input, writes ignored
    supply_low = 1'b1; #1;
    check("R3 low", cfg_rd_data[6], 1'b1);
    write_cfg(8'h40);
    supply_low = 1'b0; #1;
    check("R3 write ignored", cfg_rd_data[6], 1'b0);

    // R2 / R4 encoding and reserved bits
    write_cfg(8'hFF);
    check("R2 R4 all ones", cfg_rd_data, 8'hBB);
    write_cfg(8'h00);
    check("R2 R4 all zeros", cfg_rd_data, 8'h3A);
    write_cfg(8'h81);
    check("R2 code 11", cfg_rd_data, 8'hBB);

    // R6 R5 R2 every precision, directed
    run_conv(8'h00, 16'hFFFF, 0, 0, 0, "R6 R5 14b");
    run_conv(8'h80, 16'hFFFF, 0, 0, 0, "R6 R5 13b");
    run_conv(8'h01, 16'hFFFF, 0, 0, 0, "R6 R5 12b");
    run_conv(8'h81, 16'hFFFF, 0, 0, 0, "R6 R5 11b");

    // R7 start while busy ignored
    run_conv(8'h01, 16'hA5A7, 1, 0, 0, "R7 restart ignored");
    // R9 write during busy: length and masking kept
    run_conv(8'h00, 16'h1237, 0, 1, 8'h81, "R9 latched");
    check("R9 write took effect", cfg_rd_data, 8'hBB);

    // constrained random conversions
    for (int i = 0; i < 12; i++) begin
      c = 8'($urandom());
      r = 16'($urandom());
      run_conv(c, r, 0, 0, 0, "R6 R5 random");
      check("R2 R4 random readback", cfg_rd_data, exp_rd(c, supply_low));
    end

    // R8 soft reset mid conversion
    write_cfg(8'h81);
    adc_raw = 16'hFFFF;
    pulse_start();
    repeat (10) @(negedge clk);
    r = result;
    soft_reset = 1'b1; start = 1'b1; cfg_wr_en = 1'b1; cfg_wr_data = 8'h81;
    @(negedge clk);
    soft_reset = 1'b0; start = 1'b0; cfg_wr_en = 1'b0;
    check("R8 abort busy", busy, 1'b0);
    check("R8 no done", done, 1'b0);
    check("R8 cfg restored", cfg_rd_data, 8'h3A);
    n = 1;
    while (settling) begin
      if (n == 20) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (settling) n++;
      if (busy) begin check("R7 start in settling", busy, 1'b0); break; end
    end
    check("R8 settle length", n, 150 * TICKS);
    check("R8 result untouched", result, r);
    run_conv(8'h80, 16'hFFFF, 0, 0, 0, "R8 after settle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule